// File: doc/BRIEF.md
# Two-Port Mailbox with Cross-Side Doorbells

This block is a byte-wide register file that a host processor and a management controller share. Each side has its own plain register port: an offset, write data, a write strobe, a read strobe and a registered read-data output. The shared space holds a run of message bytes, a flag byte, two status bytes, one control register per side and two interrupt-enable bytes per side. The host moves a whole message by reading or writing every message byte in turn. The controller answers through the same bytes and the flag byte.

Each control register holds a doorbell. When one side writes its send bit, the doorbell status bit in the other side's control register is raised. That status bit stays set until its owner writes 1 to it. The controller raises status bits, including a sticky attention bit, by writing ones into the status bytes. The host removes them by writing ones.

Each side has a registered, level-sensitive interrupt line. It is fed by the status bits that side has enabled and by its own doorbell status bit while that bit is not masked. A parameter selects which action wins when a set and a clear of the same bit fall in the same cycle.

Top module: `mbox_doorbell_regs`

## Requirements
- R1: After reset every register reads 0 on both ports and both interrupt outputs are low.
- R2: A read strobe sampled at a clock edge loads the addressed byte into that port's read data at that same edge. The read data holds its value until the next read strobe.
- R3: Message bytes occupy offsets 0 up to DATA_REGS-1. Either side can write them and both sides read them. When both sides write the same byte in the same cycle, the controller's value is kept.
- R4: The flag byte at offset 0x0F is written only by the controller, and host writes to it are ignored. Bit 0 of the flag byte means a controller reset and bit 1 means completion. The block stores these bits and does not act on them.
- R5: The status bytes sit at 0x10 and 0x11, and bit 7 of 0x11 is the attention bit. A controller write sets each bit where the written data has a 1. A host write clears each bit where the written data has a 1. A 0 in either write leaves that bit unchanged.
- R6: With SET_WINS=1, a controller set and a host clear of the same status bit in the same cycle leave the bit set.
- R7: The controller's control register is at 0x12 and the host's is at 0x13. In each, bit 7 is the doorbell status, bit 1 is the mask, which stores the written value, and bit 0 is send, which always reads 0. Each side can write only its own control register; its writes to the other side's control register are ignored.
- R8: Writing 1 to bit 0 of 0x13 sets bit 7 of 0x12, and writing 1 to bit 0 of 0x12 sets bit 7 of 0x13. Writing 1 to bit 7 of a side's own control register clears that bit. With SET_WINS=1, a ring arriving in the same cycle as the clear wins.
- R9: The enable bytes for status 0 and status 1 are at 0x14 and 0x15 for the controller and at 0x16 and 0x17 for the host. Each side can write only its own pair. Both sides can read all four.
- R10: host_irq is a registered value. It is the OR of every status bit whose matching host-enable bit is set, together with bit 7 of 0x13 while bit 1 of 0x13 is clear. It changes one edge after the register state changes.
- R11: ctl_irq is formed in the same way from the controller's enables and from 0x12, with the same one-edge delay.
- R12: Offsets from 0x18 up to the top of the address range, and any address whose bits above bit 4 are not zero, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data, registered |
| ctl_addr | input | ADDR_W | Controller register offset |
| ctl_wdata | input | 8 | Controller write data |
| ctl_wr | input | 1 | Controller write strobe |
| ctl_rd | input | 1 | Controller read strobe |
| ctl_rdata | output | 8 | Controller read data, registered |
| host_irq | output | 1 | Host interrupt level |
| ctl_irq | output | 1 | Controller interrupt level |

## Verification
A write takes effect at the edge that samples its strobe, so a read issued in the next cycle returns the new value. Read data is due at the edge that samples the read strobe, and the bench samples it at the following falling edge. An interrupt changes one edge after the write that altered the state behind it. For that reason the bench samples each interrupt line twice: at the falling edge right after the write, where it must still show the old level, and at the next falling edge, where it must show the new level.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned MAP_W = 5;
   localparam logic [4:0] OFS_FLAG  = 5'h0F;
   localparam logic [4:0] OFS_STAT0 = 5'h10;
   localparam logic [4:0] OFS_STAT1 = 5'h11;
   localparam logic [4:0] OFS_CCTRL = 5'h12;
   localparam logic [4:0] OFS_HCTRL = 5'h13;
   localparam logic [4:0] OFS_CEN0  = 5'h14;
   localparam logic [4:0] OFS_CEN1  = 5'h15;
   localparam logic [4:0] OFS_HEN0  = 5'h16;
   localparam logic [4:0] OFS_HEN1  = 5'h17;
   localparam int unsigned CB_STATUS = 7;
   localparam int unsigned CB_MASK   = 1;
   localparam int unsigned CB_SEND   = 0;

   typedef struct packed {
      logic       we;
      logic [4:0] ofs;
      logic [7:0] d;
   } mbx_wr_t;
endpackage

// File: rtl/mbx_w1c_byte.sv
module mbx_w1c_byte #(
   parameter int WIDTH    = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic nxt;
      if (SET_WINS) begin : g_set_wins
         assign nxt = set_i[b] | (q_o[b] & ~clr_i[b]);
      end else begin : g_clr_wins
         assign nxt = (set_i[b] | q_o[b]) & ~clr_i[b];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o[b] <= 1'b0;
         else        q_o[b] <= nxt;
      end
   end
endmodule

// File: rtl/mbx_ctrl_reg.sv
module mbx_ctrl_reg
   import mbx_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [7:0] wdata_i,
   input  logic       ring_i,
   output logic [7:0] q_o,
   output logic       send_o
);
   logic stat_q;
   logic mask_q;

   mbx_w1c_byte #(.WIDTH(1), .SET_WINS(SET_WINS)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ring_i),
      .clr_i (wr_i & wdata_i[CB_STATUS]),
      .q_o   (stat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= 1'b0;
      else if (wr_i) mask_q <= wdata_i[CB_MASK];
   end

   assign send_o = wr_i & wdata_i[CB_SEND];

   always_comb begin
      q_o              = '0;
      q_o[CB_STATUS]   = stat_q;
      q_o[CB_MASK]     = mask_q;
   end
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port
   import mbx_pkg::*;
#(
   parameter int DATA_REGS = 15
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_i,
   input  logic                   hit_i,
   input  logic [4:0]             ofs_i,
   input  logic [DATA_REGS*8-1:0] data_i,
   input  logic [7:0]             flag_i,
   input  logic [7:0]             stat0_i,
   input  logic [7:0]             stat1_i,
   input  logic [7:0]             cctrl_i,
   input  logic [7:0]             hctrl_i,
   input  logic [7:0]             cen0_i,
   input  logic [7:0]             cen1_i,
   input  logic [7:0]             hen0_i,
   input  logic [7:0]             hen1_i,
   output logic [7:0]             rdata_o
);
   logic [7:0] sel;

   always_comb begin
      sel = '0;
      if (hit_i) begin
         for (int i = 0; i < DATA_REGS; i++) begin
            if (ofs_i == 5'(i)) sel = data_i[i*8 +: 8];
         end
         case (ofs_i)
            OFS_FLAG:  sel = flag_i;
            OFS_STAT0: sel = stat0_i;
            OFS_STAT1: sel = stat1_i;
            OFS_CCTRL: sel = cctrl_i;
            OFS_HCTRL: sel = hctrl_i;
            OFS_CEN0:  sel = cen0_i;
            OFS_CEN1:  sel = cen1_i;
            OFS_HEN0:  sel = hen0_i;
            OFS_HEN1:  sel = hen1_i;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= sel;
   end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen
   import mbx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] stat0_i,
   input  logic [7:0] stat1_i,
   input  logic [7:0] en0_i,
   input  logic [7:0] en1_i,
   input  logic [7:0] ctrl_i,
   output logic       irq_o
);
   logic lvl;
   assign lvl = (|(stat0_i & en0_i)) | (|(stat1_i & en1_i))
              | (ctrl_i[CB_STATUS] & ~ctrl_i[CB_MASK]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= lvl;
   end
endmodule

// File: rtl/mbox_doorbell_regs.sv
module mbox_doorbell_regs
   import mbx_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_REGS = 15,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic [7:0]        host_rdata,
   input  logic [ADDR_W-1:0] ctl_addr,
   input  logic [7:0]        ctl_wdata,
   input  logic              ctl_wr,
   input  logic              ctl_rd,
   output logic [7:0]        ctl_rdata,
   output logic              host_irq,
   output logic              ctl_irq
);
   localparam int DATA_W = DATA_REGS * 8;

   if (ADDR_W < int'(MAP_W)) begin : g_bad_addr
      $error("ADDR_W must cover the 5-bit register map");
   end
   if (DATA_REGS < 1 || DATA_REGS > 15) begin : g_bad_depth
      $error("DATA_REGS must lie in 1..15");
   end

   logic    h_hit, c_hit;
   mbx_wr_t hw, cw;

   if (ADDR_W > int'(MAP_W)) begin : g_wide
      assign h_hit = ~|host_addr[ADDR_W-1:MAP_W];
      assign c_hit = ~|ctl_addr[ADDR_W-1:MAP_W];
   end else begin : g_exact
      assign h_hit = 1'b1;
      assign c_hit = 1'b1;
   end

   assign hw = '{we: host_wr & h_hit, ofs: host_addr[4:0], d: host_wdata};
   assign cw = '{we: ctl_wr & c_hit,  ofs: ctl_addr[4:0],  d: ctl_wdata};

   logic [DATA_W-1:0] data_flat;
   logic [7:0] flag_q, stat0_q, stat1_q, cctrl_q, hctrl_q;
   logic [7:0] cen0_q, cen1_q, hen0_q, hen1_q;
   logic       h_send, c_send;

   for (genvar i = 0; i < DATA_REGS; i++) begin : g_data
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          byte_q <= '0;
         else if (cw.we && cw.ofs == 5'(i))   byte_q <= cw.d;
         else if (hw.we && hw.ofs == 5'(i))   byte_q <= hw.d;
      end
      assign data_flat[i*8 +: 8] = byte_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         cen0_q <= '0;
         cen1_q <= '0;
         hen0_q <= '0;
         hen1_q <= '0;
      end else begin
         if (cw.we && cw.ofs == OFS_FLAG) flag_q <= cw.d;
         if (cw.we && cw.ofs == OFS_CEN0) cen0_q <= cw.d;
         if (cw.we && cw.ofs == OFS_CEN1) cen1_q <= cw.d;
         if (hw.we && hw.ofs == OFS_HEN0) hen0_q <= hw.d;
         if (hw.we && hw.ofs == OFS_HEN1) hen1_q <= hw.d;
      end
   end

   mbx_w1c_byte #(.WIDTH(8), .SET_WINS(SET_WINS)) u_stat0 (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i ((cw.we && cw.ofs == OFS_STAT0) ? cw.d : 8'h00),
      .clr_i ((hw.we && hw.ofs == OFS_STAT0) ? hw.d : 8'h00),
      .q_o   (stat0_q)
   );

   mbx_w1c_byte #(.WIDTH(8), .SET_WINS(SET_WINS)) u_stat1 (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i ((cw.we && cw.ofs == OFS_STAT1) ? cw.d : 8'h00),
      .clr_i ((hw.we && hw.ofs == OFS_STAT1) ? hw.d : 8'h00),
      .q_o   (stat1_q)
   );

   mbx_ctrl_reg #(.SET_WINS(SET_WINS)) u_hctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (hw.we && hw.ofs == OFS_HCTRL),
      .wdata_i (hw.d),
      .ring_i  (c_send),
      .q_o     (hctrl_q),
      .send_o  (h_send)
   );

   mbx_ctrl_reg #(.SET_WINS(SET_WINS)) u_cctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cw.we && cw.ofs == OFS_CCTRL),
      .wdata_i (cw.d),
      .ring_i  (h_send),
      .q_o     (cctrl_q),
      .send_o  (c_send)
   );

   mbx_rd_port #(.DATA_REGS(DATA_REGS)) u_host_rd (
      .clk (clk), .rst_n (rst_n), .rd_i (host_rd), .hit_i (h_hit),
      .ofs_i (host_addr[4:0]), .data_i (data_flat), .flag_i (flag_q),
      .stat0_i (stat0_q), .stat1_i (stat1_q), .cctrl_i (cctrl_q),
      .hctrl_i (hctrl_q), .cen0_i (cen0_q), .cen1_i (cen1_q),
      .hen0_i (hen0_q), .hen1_i (hen1_q), .rdata_o (host_rdata)
   );

   mbx_rd_port #(.DATA_REGS(DATA_REGS)) u_ctl_rd (
      .clk (clk), .rst_n (rst_n), .rd_i (ctl_rd), .hit_i (c_hit),
      .ofs_i (ctl_addr[4:0]), .data_i (data_flat), .flag_i (flag_q),
      .stat0_i (stat0_q), .stat1_i (stat1_q), .cctrl_i (cctrl_q),
      .hctrl_i (hctrl_q), .cen0_i (cen0_q), .cen1_i (cen1_q),
      .hen0_i (hen0_q), .hen1_i (hen1_q), .rdata_o (ctl_rdata)
   );

   mbx_irq_gen u_host_irq (
      .clk (clk), .rst_n (rst_n), .stat0_i (stat0_q), .stat1_i (stat1_q),
      .en0_i (hen0_q), .en1_i (hen1_q), .ctrl_i (hctrl_q), .irq_o (host_irq)
   );

   mbx_irq_gen u_ctl_irq (
      .clk (clk), .rst_n (rst_n), .stat0_i (stat0_q), .stat1_i (stat1_q),
      .en0_i (cen0_q), .en1_i (cen1_q), .ctrl_i (cctrl_q), .irq_o (ctl_irq)
   );
endmodule

// File: rtl/mbox_doorbell_regs_chk.sv
module mbox_doorbell_regs_chk
   import mbx_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter bit SET_WINS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_wd0,
   input logic              host_wd7,
   input logic              ctl_wr,
   input logic [ADDR_W-1:0] ctl_addr,
   input logic              ctl_wd7,
   input logic [7:0]        host_rdata,
   input logic              host_irq,
   input logic              ctl_irq,
   input logic              hctrl_stat,
   input logic              hctrl_mask,
   input logic              cctrl_stat,
   input logic              cctrl_mask,
   input logic              attn
);
   localparam logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(OFS_STAT1);
   localparam logic [ADDR_W-1:0] A_CCTRL = ADDR_W'(OFS_CCTRL);
   localparam logic [ADDR_W-1:0] A_HCTRL = ADDR_W'(OFS_HCTRL);
   localparam logic [ADDR_W-1:0] A_TOP   = ADDR_W'(5'h18);

   AST_HOST_SEND_RINGS: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_addr == A_HCTRL && host_wd0
      && !(ctl_wr && ctl_addr == A_CCTRL && ctl_wd7) |=> cctrl_stat); // R8

   AST_ATTN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      attn && !(host_wr && host_addr == A_STAT1 && host_wd7) |=> attn); // R5

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      SET_WINS && ctl_wr && ctl_addr == A_STAT1 && ctl_wd7 |=> attn); // R6

   AST_SEND_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_addr == A_HCTRL |=> !host_rdata[0]); // R7

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_addr >= A_TOP |=> host_rdata == 8'h00); // R12

   AST_HOST_DOORBELL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      hctrl_stat && !hctrl_mask |=> host_irq); // R10

   AST_CTL_DOORBELL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      cctrl_stat && !cctrl_mask |=> ctl_irq); // R11
endmodule

bind mbox_doorbell_regs mbox_doorbell_regs_chk #(
   .ADDR_W   (ADDR_W),
   .SET_WINS (SET_WINS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .host_wd0   (host_wdata[0]),
   .host_wd7   (host_wdata[7]),
   .ctl_wr     (ctl_wr),
   .ctl_addr   (ctl_addr),
   .ctl_wd7    (ctl_wdata[7]),
   .host_rdata (host_rdata),
   .host_irq   (host_irq),
   .ctl_irq    (ctl_irq),
   .hctrl_stat (hctrl_q[7]),
   .hctrl_mask (hctrl_q[1]),
   .cctrl_stat (cctrl_q[7]),
   .cctrl_mask (cctrl_q[1]),
   .attn       (stat1_q[7])
);

// File: tb/mbox_doorbell_regs_bench.sv
`timescale 1ns/1ps
module mbox_doorbell_regs_bench;
   localparam int AW    = 5;
   localparam int NDATA = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] host_addr = '0, ctl_addr = '0;
   logic [7:0]    host_wdata = '0, ctl_wdata = '0;
   logic          host_wr = 1'b0, host_rd = 1'b0, ctl_wr = 1'b0, ctl_rd = 1'b0;
   logic [7:0]    host_rdata, ctl_rdata;
   logic          host_irq, ctl_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   mbox_doorbell_regs #(.ADDR_W(AW), .DATA_REGS(NDATA), .SET_WINS(1'b1)) u_mbox_doorbell_regs (
      .clk (clk), .rst_n (rst_n),
      .host_addr (host_addr), .host_wdata (host_wdata), .host_wr (host_wr),
      .host_rd (host_rd), .host_rdata (host_rdata),
      .ctl_addr (ctl_addr), .ctl_wdata (ctl_wdata), .ctl_wr (ctl_wr),
      .ctl_rd (ctl_rd), .ctl_rdata (ctl_rdata),
      .host_irq (host_irq), .ctl_irq (ctl_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic hw(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic cw(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); ctl_addr = a; ctl_wdata = d; ctl_wr = 1'b1;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic bw(input logic [4:0] ha, input logic [7:0] hd,
                     input logic [4:0] ca, input logic [7:0] cd);
      @(negedge clk);
      host_addr = ha; host_wdata = hd; host_wr = 1'b1;
      ctl_addr = ca; ctl_wdata = cd; ctl_wr = 1'b1;
      @(negedge clk); host_wr = 1'b0; ctl_wr = 1'b0;
   endtask

   task automatic hr(input logic [4:0] a, output logic [7:0] v);
      @(negedge clk); host_addr = a; host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0; v = host_rdata;
   endtask

   task automatic cr(input logic [4:0] a, output logic [7:0] v);
      @(negedge clk); ctl_addr = a; ctl_rd = 1'b1;
      @(negedge clk); ctl_rd = 1'b0; v = ctl_rdata;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 host_irq", {7'd0, host_irq}, 8'h00);
      chk("R1 ctl_irq",  {7'd0, ctl_irq},  8'h00);
      for (int a = 0; a < 32; a++) begin
         hr(5'(a), v); chk("R1 host read", v, 8'h00);
         cr(5'(a), v); chk("R1 ctl read",  v, 8'h00);
      end

      // R3 / R2: message bytes from both sides
      for (int i = 0; i < NDATA; i++) hw(5'(i), 8'(i*37 + 5));
      for (int i = 0; i < NDATA; i++) begin
         cr(5'(i), v); chk("R3 host-written byte", v, 8'(i*37 + 5));
      end
      for (int i = 0; i < NDATA; i++) cw(5'(i), 8'(i*11) ^ 8'hA5);
      for (int i = 0; i < NDATA; i++) begin
         hr(5'(i), v); chk("R2 R3 ctl-written byte", v, 8'(i*11) ^ 8'hA5);
      end
      bw(5'd2, 8'h11, 5'd2, 8'h22);
      hr(5'd2, v); chk("R3 collision", v, 8'h22);

      // R4 flag byte
      hw(5'h0F, 8'hFF);
      hr(5'h0F, v); chk("R4 host write ignored", v, 8'h00);
      cw(5'h0F, 8'h03);
      hr(5'h0F, v); chk("R4 flag value", v, 8'h03);

      // R5 / R10 status bits through host enables
      for (int s = 0; s < 2; s++) begin
         for (int b = 0; b < 8; b++) begin
            hw(5'(22 + s), 8'(1 << b));
            cw(5'(16 + s), 8'(1 << b));
            chk("R10 irq not early", {7'd0, host_irq}, 8'h00);
            tick();
            chk("R10 irq raised", {7'd0, host_irq}, 8'h01);
            hr(5'(16 + s), v); chk("R5 status set", v, 8'(1 << b));
            hw(5'(16 + s), 8'h00);
            hr(5'(16 + s), v); chk("R5 zero write no effect", v, 8'(1 << b));
            hw(5'(16 + s), 8'(1 << b));
            hr(5'(16 + s), v); chk("R5 w1c", v, 8'h00);
            chk("R10 irq dropped", {7'd0, host_irq}, 8'h00);
            hw(5'(22 + s), ~8'(1 << b));
            cw(5'(16 + s), 8'(1 << b));
            tick();
            chk("R10 disabled bit gated", {7'd0, host_irq}, 8'h00);
            hw(5'(16 + s), 8'(1 << b));
            hw(5'(22 + s), 8'h00);
         end
      end

      // R11 status bits through controller enables
      for (int s = 0; s < 2; s++) begin
         for (int b = 0; b < 8; b++) begin
            cw(5'(20 + s), 8'(1 << b));
            cw(5'(16 + s), 8'(1 << b));
            chk("R11 irq not early", {7'd0, ctl_irq}, 8'h00);
            tick();
            chk("R11 irq raised", {7'd0, ctl_irq}, 8'h01);
            hw(5'(16 + s), 8'(1 << b));
            tick();
            chk("R11 irq dropped", {7'd0, ctl_irq}, 8'h00);
            cw(5'(20 + s), 8'h00);
         end
      end

      // R9 enable ownership
      hw(5'h14, 8'hFF);
      cr(5'h14, v); chk("R9 host write to ctl enable ignored", v, 8'h00);
      cw(5'h15, 8'h5A);
      hr(5'h15, v); chk("R9 ctl enable readable", v, 8'h5A);
      cw(5'h17, 8'hFF);
      hr(5'h17, v); chk("R9 ctl write to host enable ignored", v, 8'h00);
      hw(5'h16, 8'hC3);
      cr(5'h16, v); chk("R9 host enable readable", v, 8'hC3);
      hw(5'h16, 8'h00);
      cw(5'h15, 8'h00);

      // R6 set wins
      bw(5'h11, 8'h80, 5'h11, 8'h80);
      hr(5'h11, v); chk("R6 set beats clear", v, 8'h80);
      hw(5'h11, 8'h80);
      hr(5'h11, v); chk("R5 attention cleared", v, 8'h00);

      // R7 / R8 doorbells
      hw(5'h13, 8'h01);
      cr(5'h12, v); chk("R8 host ring", v, 8'h80);
      chk("R11 doorbell irq", {7'd0, ctl_irq}, 8'h01);
      hr(5'h13, v); chk("R7 send reads 0", v, 8'h00);
      cw(5'h12, 8'h02);
      tick();
      chk("R11 masked doorbell", {7'd0, ctl_irq}, 8'h00);
      cr(5'h12, v); chk("R7 mask stored", v, 8'h82);
      cw(5'h12, 8'h80);
      cr(5'h12, v); chk("R8 w1c doorbell", v, 8'h00);
      hw(5'h12, 8'h83);
      cr(5'h12, v); chk("R7 foreign ctrl write ignored", v, 8'h00);
      cw(5'h12, 8'h01);
      hr(5'h13, v); chk("R8 ctl ring", v, 8'h80);
      chk("R10 doorbell irq", {7'd0, host_irq}, 8'h01);
      hw(5'h13, 8'h02);
      tick();
      chk("R10 masked doorbell", {7'd0, host_irq}, 8'h00);
      hr(5'h13, v); chk("R7 host mask stored", v, 8'h82);
      bw(5'h13, 8'h80, 5'h12, 8'h01);
      hr(5'h13, v); chk("R8 ring beats clear", v, 8'h80);
      hw(5'h13, 8'h80);
      hr(5'h13, v); chk("R8 host w1c", v, 8'h00);

      // R12 unmapped offsets
      for (int a = 24; a < 32; a++) begin
         hw(5'(a), 8'hFF);
         cw(5'(a), 8'hFF);
         hr(5'(a), v); chk("R12 host unmapped", v, 8'h00);
         cr(5'(a), v); chk("R12 ctl unmapped", v, 8'h00);
      end
      hr(5'd0, v); chk("R12 no aliasing", v, 8'hA5);

      summary();
      $finish;
   end
endmodule